// File: doc/BRIEF.md
# Ultrasonic Ranging Measurement Controller

This block drives a pulse-echo ultrasonic range sensor on a fixed measurement schedule. Each cycle raises a trigger pulse of fixed length. It then waits for the returned echo and counts the clock cycles for which the echo stays high. The count is divided by a calibration constant (clock cycles per centimetre of range) to give whole centimetres, limited to the supported maximum. The result is presented both as a binary value and as two BCD digits.

A proximity flag marks obstacles that are closer than a threshold. A one-cycle strobe tells a downstream consumer, such as a serial sender, that a new value is available. The strobe fires only when the value has changed since the last report. After reset the first report is unconditional.

The echo input is asynchronous and passes through a two-flop synchronizer. The asynchronous active-low reset is released synchronously inside the block. A timeout covers two faults: an echo that never starts, and an echo that stays high too long. Either fault ends the wait, so the schedule can never stall.

Top module: `sonar_range_ctrl`

## Requirements
- R1: Each measurement cycle begins with `trig_o` high for exactly TRIG_CYCLES consecutive clock cycles, and `trig_o` is high at no other time.
- R2: Successive rising edges of `trig_o` are exactly PERIOD_CYCLES clock cycles apart. The first trigger starts within a few cycles of reset release.
- R3: If the echo stays high for W clock cycles, with W below ECHO_TO_CYCLES, the distance is floor(W / CNT_PER_CM), saturated at MAX_CM.
- R4: If no echo rising edge is seen within WAIT_TO_CYCLES cycles of the trigger ending, the distance is MAX_CM. The same holds if the echo stays high for ECHO_TO_CYCLES cycles. In both cases the next trigger still follows on schedule.
- R5: `tens_o` and `ones_o` are the BCD tens and units digits of `dist_cm_o`: distance = 10*tens + ones, with each digit in 0..9.
- R6: `near_o` is 1 exactly when the last measured distance is below ALERT_CM.
- R7: `report_o` is a single-cycle pulse, at most one per cycle. It fires only when the new distance differs from the last reported distance. The first measurement after reset always reports.
- R8: `busy_o` is low only in the cooldown state. `report_o` is raised only while `busy_o` is low. The distance outputs do not change while `busy_o` stays low.
- R9: During reset, `trig_o`, `report_o` and `near_o` are 0, the distance and both digits are 0, and `state_o` reads 0 (clear state). The state codes run in measurement order: 0 clear, 1 trigger, 2 echo wait, 3 echo measure, 4 divide, 5 BCD, 6 update, 7 report, 8 cooldown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| echo_i | input | 1 | Raw echo line from the sensor (asynchronous) |
| trig_o | output | 1 | Trigger pulse to the sensor |
| dist_cm_o | output | DIST_W | Measured distance in centimetres |
| tens_o | output | 4 | BCD tens digit of the distance |
| ones_o | output | 4 | BCD units digit of the distance |
| near_o | output | 1 | Obstacle closer than ALERT_CM |
| report_o | output | 1 | One-cycle strobe on a changed distance |
| busy_o | output | 1 | Low only while cooling down between measurements |
| state_o | output | 4 | Current state code |

## Verification
The bench builds the block with a 5-cycle trigger, 4 cycles per centimetre, a 40-cycle echo-start timeout and a 400-cycle period. With these values one measurement takes only a few hundred clocks. That makes it possible to sweep every echo width from 0 to 210 cycles, which covers every distance from 0 to 49, each rounding boundary, the saturation region and the echo-high timeout at 200 cycles. A missing echo and an over-long echo are also applied, along with repeated equal readings (no report expected) and a reset in mid-run (report expected again).

// File: rtl/sonar_pkg.sv
package sonar_pkg;

  // Encodings are in measurement order; the values are visible on state_o.
  typedef enum logic [3:0] {
    ST_CLEAR     = 4'd0,
    ST_TRIG      = 4'd1,
    ST_ECHO_WAIT = 4'd2,
    ST_ECHO_MEAS = 4'd3,
    ST_CALC      = 4'd4,
    ST_BCD       = 4'd5,
    ST_UPDATE    = 4'd6,
    ST_REPORT    = 4'd7,
    ST_COOL      = 4'd8
  } sonar_state_e;

  localparam int unsigned STATE_W = 4;

endpackage

// File: rtl/sonar_rst_sync.sv
module sonar_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  // Assert asynchronously, deassert after STAGES clean edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/sonar_sync.sv
module sonar_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];

endmodule

// File: rtl/sonar_div.sv
// Iterative divide by a constant using repeated subtraction.
// The quotient stops at QMAX, which gives range saturation for free.
module sonar_div #(
  parameter int unsigned DW      = 16,
  parameter int unsigned QW      = 6,
  parameter int unsigned DIVISOR = 4,
  parameter int unsigned QMAX    = 49
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] dividend_i,
  input  logic          run_i,
  output logic [QW-1:0] quot_o,
  output logic          done_o
);

  localparam logic [DW-1:0] K_VAL = DW'(DIVISOR);
  localparam logic [QW-1:0] Q_CAP = QW'(QMAX);

  logic [DW-1:0] rem_q;
  logic [QW-1:0] quo_q;
  logic          step_ok;

  assign step_ok = (rem_q >= K_VAL) && (quo_q < Q_CAP);
  assign done_o  = !step_ok;
  assign quot_o  = quo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
    end else if (load_i) begin
      rem_q <= dividend_i;
      quo_q <= '0;
    end else if (run_i && step_ok) begin
      rem_q <= rem_q - K_VAL;
      quo_q <= quo_q + 1'b1;
    end
  end

endmodule

// File: rtl/sonar_bcd.sv
// Binary to two BCD digits for values 0..99.
module sonar_bcd #(
  parameter int unsigned VW = 6
) (
  input  logic [VW-1:0] val_i,
  output logic [3:0]    tens_o,
  output logic [3:0]    ones_o
);

  int v;
  int t;

  always_comb begin
    v = int'(val_i);
    t = 0;
    for (int k = 1; k < 10; k++) begin
      if (v >= 10 * k) t = k;
    end
    tens_o = 4'(t);
    ones_o = 4'(v - 10 * t);
  end

endmodule

// File: rtl/sonar_range_ctrl.sv
module sonar_range_ctrl
  import sonar_pkg::*;
#(
  parameter int unsigned TRIG_CYCLES    = 1000,
  parameter int unsigned CNT_PER_CM     = 5800,
  parameter int unsigned MAX_CM         = 49,
  parameter int unsigned ALERT_CM       = 5,
  parameter int unsigned WAIT_TO_CYCLES = 1000000,
  parameter int unsigned ECHO_TO_CYCLES = (MAX_CM + 1) * CNT_PER_CM,
  parameter int unsigned PERIOD_CYCLES  = 2500000,
  localparam int unsigned DIST_W = $clog2(MAX_CM + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              echo_i,
  output logic              trig_o,
  output logic [DIST_W-1:0] dist_cm_o,
  output logic [3:0]        tens_o,
  output logic [3:0]        ones_o,
  output logic              near_o,
  output logic              report_o,
  output logic              busy_o,
  output logic [3:0]        state_o
);

  localparam int unsigned TO_MAX = (WAIT_TO_CYCLES > ECHO_TO_CYCLES) ? WAIT_TO_CYCLES : ECHO_TO_CYCLES;
  localparam int unsigned CNT_W  = $clog2(TO_MAX + 1);
  localparam int unsigned PH_W   = $clog2(PERIOD_CYCLES);

  localparam logic [CNT_W-1:0]  WAIT_LAST = CNT_W'(WAIT_TO_CYCLES - 1);
  localparam logic [CNT_W-1:0]  ECHO_CAP  = CNT_W'(ECHO_TO_CYCLES);
  localparam logic [PH_W-1:0]   TRIG_LAST = PH_W'(TRIG_CYCLES - 1);
  localparam logic [PH_W-1:0]   PER_LAST  = PH_W'(PERIOD_CYCLES - 1);
  localparam logic [DIST_W-1:0] ALERT_LIM = DIST_W'(ALERT_CM);

  // ---------------- reset and input conditioning
  logic rst_in_n;
  logic echo_s;
  logic echo_d;
  logic echo_rise;

  sonar_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_in_n)
  );

  sonar_sync #(.STAGES(2)) u_echo_sync (
    .clk   (clk),
    .rst_n (rst_in_n),
    .d_i   (echo_i),
    .q_o   (echo_s)
  );

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) echo_d <= 1'b0;
    else           echo_d <= echo_s;
  end

  assign echo_rise = echo_s && !echo_d;

  // ---------------- control state
  sonar_state_e      state_q, state_n;
  logic [PH_W-1:0]   phase_q, phase_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              div_load;
  logic              div_run;
  logic              div_done;
  logic [DIST_W-1:0] div_quot;

  // Phase: free running over one period, aligned to the trigger start.
  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    div_run  = 1'b0;
    if (state_q == ST_CLEAR || phase_q == PER_LAST) phase_n = '0;
    else                                           phase_n = phase_q + 1'b1;

    unique case (state_q)
      ST_CLEAR: state_n = ST_TRIG;
      ST_TRIG: begin
        if (phase_q == TRIG_LAST) begin
          state_n = ST_ECHO_WAIT;
          cnt_n   = '0;
        end
      end
      ST_ECHO_WAIT: begin
        if (echo_rise) begin
          state_n = ST_ECHO_MEAS;
          cnt_n   = CNT_W'(1);
        end else if (cnt_q == WAIT_LAST) begin
          state_n = ST_CALC;      // no echo: treat as beyond range
          cnt_n   = ECHO_CAP;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_ECHO_MEAS: begin
        if (!echo_s || cnt_q == ECHO_CAP) state_n = ST_CALC;
        else                              cnt_n   = cnt_q + 1'b1;
      end
      ST_CALC: begin
        div_run = 1'b1;
        if (div_done) state_n = ST_BCD;
      end
      ST_BCD:    state_n = ST_UPDATE;
      ST_UPDATE: state_n = ST_REPORT;
      ST_REPORT: state_n = ST_COOL;
      ST_COOL: begin
        if (phase_q == PER_LAST) state_n = ST_TRIG;
      end
      default: state_n = ST_CLEAR;
    endcase
  end

  assign div_load = (state_n == ST_CALC) && (state_q != ST_CALC);

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      state_q <= ST_CLEAR;
      phase_q <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_n;
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
    end
  end

  // ---------------- datapath
  sonar_div #(
    .DW      (CNT_W),
    .QW      (DIST_W),
    .DIVISOR (CNT_PER_CM),
    .QMAX    (MAX_CM)
  ) u_div (
    .clk        (clk),
    .rst_n      (rst_in_n),
    .load_i     (div_load),
    .dividend_i (cnt_n),
    .run_i      (div_run),
    .quot_o     (div_quot),
    .done_o     (div_done)
  );

  logic [3:0] conv_tens, conv_ones;
  logic [3:0] bcd_tens_q, bcd_ones_q;

  sonar_bcd #(.VW(DIST_W)) u_bcd (
    .val_i  (div_quot),
    .tens_o (conv_tens),
    .ones_o (conv_ones)
  );

  logic              bcd_en, upd_en, rep_en;
  logic [DIST_W-1:0] dist_q, last_q;
  logic [3:0]        tens_q, ones_q;
  logic              near_q, first_q, report_q;

  assign bcd_en = (state_q == ST_BCD);
  assign upd_en = (state_q == ST_UPDATE);
  assign rep_en = (state_q == ST_REPORT);

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      bcd_tens_q <= '0;
      bcd_ones_q <= '0;
    end else if (bcd_en) begin
      bcd_tens_q <= conv_tens;
      bcd_ones_q <= conv_ones;
    end
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      dist_q <= '0;
      tens_q <= '0;
      ones_q <= '0;
      near_q <= 1'b0;
    end else if (upd_en) begin
      dist_q <= div_quot;
      tens_q <= bcd_tens_q;
      ones_q <= bcd_ones_q;
      near_q <= (div_quot < ALERT_LIM);
    end
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      last_q   <= '0;
      first_q  <= 1'b1;
      report_q <= 1'b0;
    end else begin
      report_q <= rep_en && (first_q || (dist_q != last_q));
      if (rep_en) begin
        last_q  <= dist_q;
        first_q <= 1'b0;
      end
    end
  end

  assign trig_o    = (state_q == ST_TRIG);
  assign dist_cm_o = dist_q;
  assign tens_o    = tens_q;
  assign ones_o    = ones_q;
  assign near_o    = near_q;
  assign report_o  = report_q;
  assign busy_o    = (state_q != ST_COOL);
  assign state_o   = state_q;

endmodule

// File: rtl/sonar_range_ctrl_chk.sv
module sonar_range_ctrl_chk #(
  parameter int unsigned TRIG_CYCLES = 1000,
  parameter int unsigned MAX_CM      = 49,
  parameter int unsigned ALERT_CM    = 5,
  parameter int unsigned DIST_W      = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig_o,
  input logic [DIST_W-1:0] dist_cm_o,
  input logic [3:0]        tens_o,
  input logic [3:0]        ones_o,
  input logic              near_o,
  input logic              report_o,
  input logic              busy_o
);

  localparam int unsigned RUN_W = $clog2(TRIG_CYCLES + 2);

  logic [RUN_W-1:0] trig_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      trig_run <= '0;
    else if (trig_o) trig_run <= trig_run + 1'b1;
    else             trig_run <= '0;
  end

  AST_TRIG_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> (int'(trig_run) < int'(TRIG_CYCLES))); // R1

  AST_DIST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(dist_cm_o) <= int'(MAX_CM)); // R3

  AST_BCD_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tens_o <= 4'd9) && (ones_o <= 4'd9) &&
    (int'(tens_o) * 10 + int'(ones_o) == int'(dist_cm_o))); // R5

  AST_NEAR_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    near_o |-> (int'(dist_cm_o) < int'(ALERT_CM))); // R6

  AST_REPORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    report_o |=> !report_o); // R7

  AST_REPORT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    report_o |-> !busy_o); // R8

  AST_DIST_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o)) |-> $stable(dist_cm_o)); // R8

endmodule

bind sonar_range_ctrl sonar_range_ctrl_chk #(
  .TRIG_CYCLES (TRIG_CYCLES),
  .MAX_CM      (MAX_CM),
  .ALERT_CM    (ALERT_CM),
  .DIST_W      (DIST_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .trig_o    (trig_o),
  .dist_cm_o (dist_cm_o),
  .tens_o    (tens_o),
  .ones_o    (ones_o),
  .near_o    (near_o),
  .report_o  (report_o),
  .busy_o    (busy_o)
);

// File: tb/sonar_range_ctrl_tb.sv
module sonar_range_ctrl_tb;

  localparam int TRIG   = 5;
  localparam int CNT    = 4;
  localparam int MAXD   = 49;
  localparam int ALERT  = 5;
  localparam int WAITTO = 40;
  localparam int PERIOD = 400;
  localparam int ECHOTO = (MAXD + 1) * CNT;
  localparam int DW     = $clog2(MAXD + 1);
  localparam int WD_CYC = 190000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          echo_i;
  logic          trig_o, near_o, report_o, busy_o;
  logic [DW-1:0] dist_cm_o;
  logic [3:0]    tens_o, ones_o, state_o;

  always #10 clk = ~clk;

  sonar_range_ctrl #(
    .TRIG_CYCLES    (TRIG),
    .CNT_PER_CM     (CNT),
    .MAX_CM         (MAXD),
    .ALERT_CM       (ALERT),
    .WAIT_TO_CYCLES (WAITTO),
    .PERIOD_CYCLES  (PERIOD)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .echo_i    (echo_i),
    .trig_o    (trig_o),
    .dist_cm_o (dist_cm_o),
    .tens_o    (tens_o),
    .ones_o    (ones_o),
    .near_o    (near_o),
    .report_o  (report_o),
    .busy_o    (busy_o),
    .state_o   (state_o)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;
  int  elapsed;
  int  reports;
  int  last_rep;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    elapsed++;
    if (report_o) reports++;
  endtask

  // Wait for a trigger rise; returns with trig_o just seen high.
  task automatic find_trig(output int waited);
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!trig_o && waited < 2 * PERIOD);
  endtask

  // One measurement: entered right after a trigger rise has been seen.
  task automatic measure(input int w);
    int hi;
    int exp_d;
    int exp_r;
    bit busy_prev;
    elapsed = 0;
    reports = 0;
    do tick(); while (trig_o && elapsed < PERIOD);
    hi = elapsed;
    check(hi == TRIG, "R1", "trigger width", hi, TRIG);
    tick();
    tick();
    if (w > 0) begin
      echo_i = 1'b1;
      for (int i = 0; i < w; i++) tick();
      echo_i = 1'b0;
    end
    busy_prev = busy_o;
    while (!trig_o && elapsed < 2 * PERIOD) begin
      busy_prev = busy_o;
      tick();
    end
    check(elapsed == PERIOD, "R2", "trigger spacing", elapsed, PERIOD);
    check(busy_prev == 1'b0, "R8", "busy before next trigger", int'(busy_prev), 0);
    if (w == 0 || w >= ECHOTO) exp_d = MAXD;
    else                       exp_d = (w / CNT > MAXD) ? MAXD : w / CNT;
    check(int'(dist_cm_o) == exp_d, (w == 0 || w >= ECHOTO) ? "R4" : "R3",
          $sformatf("distance w=%0d", w), int'(dist_cm_o), exp_d);
    check(int'(tens_o) == exp_d / 10 && int'(ones_o) == exp_d % 10, "R5",
          $sformatf("bcd w=%0d", w), int'(tens_o) * 10 + int'(ones_o), exp_d);
    check(near_o == (exp_d < ALERT), "R6", $sformatf("near w=%0d", w),
          int'(near_o), int'(exp_d < ALERT));
    exp_r = (exp_d != last_rep) ? 1 : 0;
    check(reports == exp_r, "R7", $sformatf("report count w=%0d", w), reports, exp_r);
    last_rep = exp_d;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", WD_CYC, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int waited;
    rst_n    = 1'b0;
    echo_i   = 1'b0;
    last_rep = -1;
    repeat (5) @(negedge clk);
    // R9: reset values
    check(trig_o == 1'b0 && report_o == 1'b0 && near_o == 1'b0, "R9",
          "control outputs in reset", int'({trig_o, report_o, near_o}), 0);
    check(dist_cm_o == '0 && tens_o == 4'd0 && ones_o == 4'd0, "R9",
          "distance in reset", int'(dist_cm_o), 0);
    check(state_o == 4'd0, "R9", "state in reset", int'(state_o), 0);
    rst_n = 1'b1;
    find_trig(waited);
    check(waited <= 6, "R2", "first trigger after reset", waited, 6);

    // Sweep echo widths across every distance, the saturation and timeout region.
    for (int w = 0; w <= 210; w++) measure(w);
    // Equal readings in a row: the second must not report (R7).
    measure(21);
    measure(22);
    // Echo held past the high timeout (R4).
    measure(300);
    measure(0);

    // Reset in mid-run: values clear and the next report is unconditional (R7, R9).
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(dist_cm_o == '0 && near_o == 1'b0 && trig_o == 1'b0, "R9",
          "mid-run reset clears", int'(dist_cm_o), 0);
    rst_n    = 1'b1;
    last_rep = -1;
    find_trig(waited);
    measure(0);
    measure(10);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule